// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Unit

This unit takes one exception request per cycle and turns it into a control-flow redirect. A request carries a cause code and, for calls into the privileged support library, an 8-bit function code. The unit looks up the entry offset for the cause, adds it to the privileged-library base address and loads that result into the program counter. It also records the return address, with the current mode flag carried in bit 0.

When the core takes an exception while in normal mode, the unit sets the privileged-mode flag. It then exchanges eight architectural integer registers with an internal bank of eight shadow registers. The exchange goes through a single read/write register-file port and moves one register pair per cycle. While the exchange runs, `busy` is high and new requests are ignored. A one-cycle `done` pulse marks the end of the exchange. When the core is already in privileged mode, the redirect happens without any exchange.

The shadow bank has no reset, so its contents survive a reset. The privileged-library base must be 64-byte aligned.

Top module: `pal_entry`

## Requirements
- R1: After reset, `mode`, `busy`, `pc_load`, `done`, `err` and `rf_we` are all 0.
- R2: Causes 0 to 9 select the fixed offset cause × 0x80. The encoding is 0 reset, 1 machine check, 2 interprocessor interrupt, 3 clock interrupt, 4 device interrupt, 5 memory fault, 6 unaligned access, 7 illegal opcode, 8 arithmetic, 9 FP disabled.
- R3: Cause 10 is a library call. If `req_func[7]` is 1, the offset is 0x2000 + `req_func[6:0]` × 64. Otherwise it is 0x1000 + `req_func` × 64.
- R4: `saved_addr` equals `cur_pc` OR'd with the mode flag (in bit 0) as it was when the request was accepted.
- R5: A request is accepted when `req_valid` is high and `busy` is low. In the cycle after acceptance, `pc_load` is high for one cycle and `new_pc` equals `pal_base` plus the offset.
- R6: A request accepted with `mode` = 0 sets `mode`. It then exchanges integer registers 8, 9, 10, 11, 12, 13, 14 and 25 with shadow entries 0 to 7, in that order, one pair per cycle. Each cycle the old register value goes into the shadow entry and the shadow value is written to the register. `rf_we` is high only during this exchange.
- R7: `busy` is high for exactly 8 cycles after a swapping request is accepted. `done` pulses in the next cycle. Any request made while `busy` is high is ignored.
- R8: A request accepted with `mode` = 1 writes no register, raises no `busy` and leaves `mode` at 1.
- R9: Causes 11 to 15 pulse `err` in the cycle after the request. They raise no `pc_load`, start no exchange and leave `mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_cause | input | 4 | Cause code |
| req_func | input | 8 | Library call function code |
| cur_pc | input | 64 | PC of the faulting instruction |
| pal_base | input | 64 | Privileged-library base, 64-byte aligned |
| rf_rdata | input | 64 | Register-file read data (asynchronous read) |
| rf_addr | output | 5 | Register-file address during the exchange |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 64 | Register-file write data |
| new_pc | output | 64 | Redirect target |
| saved_addr | output | 64 | Return address tagged with the mode flag |
| pc_load | output | 1 | One-cycle redirect strobe |
| mode | output | 1 | Privileged-mode flag |
| busy | output | 1 | Register exchange in progress |
| done | output | 1 | One-cycle pulse at the end of the exchange |
| err | output | 1 | Unrecognised cause pulse |

## Verification
The bench targets the mode transition.

- **Exchange order.** A design that swapped on every entry would show write strobes during the second, already-privileged entry. A design that mapped the eighth shadow entry to register 15 instead of 25 would put the wrong address on the port.
- **Exchange contents.** The register file is preloaded. After a reset a second exchange follows, and it must return the first pattern from the shadow bank. A bank that lost data, or one that wrote before it read, would fail this.
- **Call offsets.** Library-call codes on both sides of bit 7, including the extreme function codes, expose a wrong base or a wrong scale.
- **Ignored requests.** A request placed in the middle of an exchange, and unrecognised causes, must produce no redirect.

// File: rtl/pal_entry.sv
module pal_entry #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 4,
  parameter int FUNC_W  = 8,
  parameter int RIDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [FUNC_W-1:0]  req_func,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    pal_base,
  input  logic [XLEN-1:0]    rf_rdata,
  output logic [RIDX_W-1:0]  rf_addr,
  output logic               rf_we,
  output logic [XLEN-1:0]    rf_wdata,
  output logic [XLEN-1:0]    new_pc,
  output logic [XLEN-1:0]    saved_addr,
  output logic               pc_load,
  output logic               mode,
  output logic               busy,
  output logic               done,
  output logic               err
);
  localparam int NSH     = 8;
  localparam int SIDX_W  = $clog2(NSH);
  localparam int OFF_W   = 14;
  localparam int LASTVEC = 9;
  localparam int CALLC   = 10;
  localparam int SLOT_SH = 6;
  localparam int VEC_SH  = 7;

  logic [XLEN-1:0]   shadow [NSH];
  logic [SIDX_W-1:0] idx;
  logic [OFF_W-1:0]  off;
  logic              known;
  logic              accept;

  assign accept = req_valid && !busy;

  always_comb begin
    known = 1'b1;
    off   = '0;
    if (int'(req_cause) <= LASTVEC)
      off = OFF_W'(req_cause) << VEC_SH;
    else if (int'(req_cause) == CALLC)
      off = (req_func[FUNC_W-1] ? 14'h2000 : 14'h1000)
            + (OFF_W'(req_func[FUNC_W-2:0]) << SLOT_SH);
    else
      known = 1'b0;
  end

  assign rf_addr  = (idx == SIDX_W'(NSH-1)) ? RIDX_W'(25) : RIDX_W'(8 + int'(idx));
  assign rf_we    = busy;
  assign rf_wdata = shadow[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= 1'b0;
      busy       <= 1'b0;
      idx        <= '0;
      pc_load    <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      new_pc     <= '0;
      saved_addr <= '0;
    end else begin
      pc_load <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      if (busy) begin
        idx <= idx + 1'b1;
        if (idx == SIDX_W'(NSH-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (accept) begin
        if (!known) begin
          err <= 1'b1;
        end else begin
          pc_load    <= 1'b1;
          new_pc     <= pal_base + XLEN'(off);
          saved_addr <= cur_pc | XLEN'(mode);
          if (!mode) begin
            mode <= 1'b1;
            busy <= 1'b1;
            idx  <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) shadow[idx] <= rf_rdata;
  end
endmodule

// File: rtl/pal_entry_chk.sv
module pal_entry_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] rf_addr,
  input logic       rf_we,
  input logic       pc_load,
  input logic       mode,
  input logic       busy,
  input logic       done,
  input logic       err
);
  p_we_in_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mode);
  p_addr_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((rf_addr >= 5'd8 && rf_addr <= 5'd14) || rf_addr == 5'd25));
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));
  p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> mode);
  p_err_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pc_load && !$rose(busy));
  p_load_sets_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> mode);
endmodule

bind pal_entry pal_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rf_addr(rf_addr), .rf_we(rf_we),
  .pc_load(pc_load), .mode(mode), .busy(busy), .done(done), .err(err)
);

// File: tb/pal_entry_tb_top.sv
module pal_entry_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_cause = 0;
  logic [7:0] req_func = 0;
  logic [63:0] cur_pc = 0, pal_base = 0, rf_rdata;
  logic [4:0] rf_addr;
  logic rf_we, pc_load, mode, busy, done, err;
  logic [63:0] rf_wdata, new_pc, saved_addr;
  logic [63:0] rf [32];
  int nchk = 0, nfail = 0, nwe = 0;
  logic [127:0] expq [$];

  always #10 clk = ~clk;

  pal_entry dut_i (.*);

  assign rf_rdata = rf[rf_addr];
  always @(posedge clk) if (rf_we) begin rf[rf_addr] <= rf_wdata; nwe++; end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [63:0] offs(input logic [3:0] c, input logic [7:0] f);
    if (c <= 9) return 64'(c) * 64'h80;
    if (f[7]) return 64'h2000 + 64'(f - 8'h80) * 64;
    return 64'h1000 + 64'(f) * 64;
  endfunction

  task automatic take(input logic [3:0] c, input logic [7:0] f, input logic [63:0] pc, input logic [63:0] base);
    @(negedge clk);
    expq.push_back({base + offs(c, f), pc | 64'(mode)});
    req_valid = 1; req_cause = c; req_func = f; cur_pc = pc; pal_base = base;
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && pc_load) begin
    if (expq.size() == 0) chk(0, "R5 unexpected pc_load", 1, 0);
    else begin
      logic [127:0] e;
      e = expq.pop_front();
      chk(new_pc == e[127:64], "R2/R3/R5 new_pc", new_pc, e[127:64]);
      chk(saved_addr == e[63:0], "R4 saved_addr", saved_addr, e[63:0]);
    end
  end

  function automatic int areg(input int k);
    return (k == 7) ? 25 : 8 + k;
  endfunction

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
  endtask

  task automatic swap_check(input string tag);
    for (int k = 0; k < 8; k++) begin
      chk(busy && rf_we, {tag, " R7 busy"}, 64'(busy), 1);
      chk(rf_addr == 5'(areg(k)), {tag, " R6 order"}, 64'(rf_addr), 64'(areg(k)));
      if (k == 3) begin req_valid = 1; req_cause = 4'd2; end
      if (k == 4) req_valid = 0;
      @(negedge clk);
    end
    chk(!busy && done, {tag, " R7 done"}, {62'd0, busy, done}, 64'd1);
    chk(mode, {tag, " R6 mode"}, 64'(mode), 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 64'hA000 + 64'(i);
    do_reset();
    @(negedge clk);
    chk(!mode && !busy && !pc_load && !done && !err && !rf_we, "R1 reset", {58'd0, mode, busy, pc_load, done, err, rf_we}, 0);
    req_valid = 1; req_cause = 4'd15; @(negedge clk); req_valid = 0;
    chk(err && !mode && !busy, "R9 err normal", {61'd0, err, mode, busy}, 64'd4);
    take(4'd5, 8'd0, 64'h1234_5670, 64'h1_0000);
    swap_check("first");
    repeat (2) @(negedge clk);
    begin
      int w0;
      w0 = nwe;
      for (int c = 0; c < 10; c++) take(4'(c), 8'd0, 64'h4000 + 64'(c * 16), 64'hFFC0);
      take(4'd10, 8'h00, 64'h800, 64'h4_0000);
      take(4'd10, 8'h7F, 64'h810, 64'h4_0000);
      take(4'd10, 8'h80, 64'h820, 64'h4_0000);
      take(4'd10, 8'hBF, 64'h830, 64'h4_0000);
      take(4'd10, 8'hFF, 64'h840, 64'h4_0040);
      @(negedge clk);
      chk(nwe == w0 && !busy && mode, "R8 no swap", 64'(nwe - w0), 0);
    end
    req_valid = 1; req_cause = 4'd12; @(negedge clk); req_valid = 0;
    chk(err && mode && !pc_load, "R9 err priv", {61'd0, err, mode, pc_load}, 64'd6);
    do_reset();
    for (int k = 0; k < 8; k++) rf[areg(k)] = 64'hB000 + 64'(k);
    @(negedge clk);
    chk(!mode && !busy, "R1 second reset", {62'd0, mode, busy}, 0);
    take(4'd8, 8'd0, 64'h9990, 64'h2_0000);
    swap_check("second");
    for (int k = 0; k < 8; k++)
      chk(rf[areg(k)] == 64'hA000 + 64'(areg(k)), "R6 contents", rf[areg(k)], 64'hA000 + 64'(areg(k)));
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 missing loads", 64'(expq.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule